// File: doc/BRIEF.md
# Completion Interrupt Moderation Engine

This block decides when one completion queue raises an interrupt. It counts the completions that are waiting to be reported. A period timer advances on an external microsecond tick. An interrupt pulse goes out when the waiting count reaches a threshold, or when the timer has run its full period while at least one completion is waiting.

The timer has two base points. In the interrupt-based mode the timer measures from the last interrupt. In the completion-based mode every completion reloads the timer. Under a steady burst the timer then never expires, so only the count threshold paces interrupts, and a quiet gap of one full period flushes whatever is waiting. A capability strap says whether the completion-based mode is available. When the strap is clear the block always uses the interrupt-based mode.

Mode, period and threshold are sampled only while nothing is waiting or in an interrupt cycle. They stay frozen while completions are waiting. Suggested software defaults are a threshold of 32, with a period of 16 in the interrupt-based mode and 3 in the completion-based mode.

Top module: `mim_moderator`

## Requirements
- R1: After reset `irq_o` is 0, `pend_cnt_o` is 0 and `expired_o` is 0. The reset configuration is the interrupt-based mode, period `DEF_PERIOD` (16) and threshold `DEF_THRESH` (32).
- R2: Each cycle with `cmpl_i` high adds one to `pend_cnt_o`, visible in the following cycle.
- R3: While `pend_cnt_o` is non-zero and at least the sampled threshold, `irq_o` is high. It rises in the cycle after the edge that registered the completion reaching the threshold.
- R4: In the interrupt-based mode the timer counts `usec_tick_i` cycles since the last interrupt, saturating at the period. It does not move without a tick. `irq_o` is high when the count has reached the period and `pend_cnt_o` is non-zero.
- R5: In the completion-based mode (`mode_req_i` = 1 with `restart_cap_i` = 1), a completion reloads the timer to 0. The interrupt fires once `period` ticks pass with no further completion, even if the timer had already expired before that completion.
- R6: In the completion-based mode, completions separated by fewer than `period` ticks never fire on time. Only the threshold fires.
- R7: `mode_req_i` values 0, 2 and 3 all select the interrupt-based mode.
- R8: With `restart_cap_i` = 0 the interrupt-based mode is used whatever `mode_req_i` is.
- R9: In a cycle with `irq_o` high, the waiting count and the timer both clear at the next edge. A completion in that same cycle leaves `pend_cnt_o` at 1.
- R10: With a sampled period of 0, every waiting completion raises `irq_o` in the cycle after it is registered.
- R11: `irq_o` is never high while `pend_cnt_o` is 0, even with the timer expired. `expired_o` reports that the timer has reached the period.
- R12: Changes on `mode_req_i`, `restart_cap_i`, `period_i` and `thresh_i` have no effect while completions are waiting. They are sampled in an interrupt cycle or an idle cycle and apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_i | input | 1 | One completion this cycle |
| usec_tick_i | input | 1 | One-cycle microsecond tick |
| mode_req_i | input | 2 | Requested timer base: 1 = restart on completion, other values = restart on interrupt |
| period_i | input | PERIOD_W | Period limit in ticks |
| thresh_i | input | COUNT_W | Completion count threshold |
| restart_cap_i | input | 1 | Strap: completion-based mode available |
| irq_o | output | 1 | Interrupt, high for each cycle in which the fire condition holds |
| pend_cnt_o | output | COUNT_W | Completions waiting to be reported |
| expired_o | output | 1 | Timer has reached the sampled period |

## Verification
The assertions take for granted that `thresh_i` fits the count width and that configuration inputs are held steady for at least one idle cycle before traffic that depends on them. They also assume `restart_cap_i` is a strap that does not toggle mid-burst. The stimulus changes mode, period, threshold and strap only while the queue is idle and then spends two idle cycles before sending completions. The one exception is a single threshold change made deliberately while completions are waiting, used to show that the change is held off. Ticks and completions are driven as single-cycle pulses between clock edges.

// File: rtl/mim_pkg.sv
package mim_pkg;

  // Requested period-mode encodings on mode_req_i
  localparam logic [1:0] MODE_REQ_FROM_IRQ  = 2'd0;
  localparam logic [1:0] MODE_REQ_FROM_CMPL = 2'd1;

  // Resolved timer base actually used by the engine
  typedef enum logic {
    TMR_FROM_IRQ  = 1'b0,
    TMR_FROM_CMPL = 1'b1
  } tmr_base_e;

  // Reserved encodings and a missing capability both fall back to IRQ base
  function automatic tmr_base_e resolve_base(input logic [1:0] req, input logic cap);
    if (cap && (req == MODE_REQ_FROM_CMPL)) return TMR_FROM_CMPL;
    return TMR_FROM_IRQ;
  endfunction

endpackage

// File: rtl/mim_cfg_hold.sv
module mim_cfg_hold
  import mim_pkg::*;
#(
  parameter int PERIOD_W   = 8,
  parameter int COUNT_W    = 8,
  parameter int DEF_PERIOD = 16,
  parameter int DEF_THRESH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [1:0]          mode_req_i,
  input  logic                cap_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [COUNT_W-1:0]  thresh_i,
  output tmr_base_e           base_q,
  output logic [PERIOD_W-1:0] period_q,
  output logic [COUNT_W-1:0]  thresh_q
);

  localparam logic [PERIOD_W-1:0] RST_PERIOD = PERIOD_W'(DEF_PERIOD);
  localparam logic [COUNT_W-1:0]  RST_THRESH = COUNT_W'(DEF_THRESH);

  tmr_base_e base_req;
  assign base_req = resolve_base(mode_req_i, cap_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= TMR_FROM_IRQ;
      period_q <= RST_PERIOD;
      thresh_q <= RST_THRESH;
    end else if (load) begin
      base_q   <= base_req;
      period_q <= period_i;
      thresh_q <= thresh_i;
    end
  end

  // R8: without the capability the completion base can never be loaded
  assert_cap_forces_irq_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cap_i) |=> (base_q == TMR_FROM_IRQ));

  // R12: configuration frozen whenever no load window is open
  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(period_q) && $stable(thresh_q) && $stable(base_q)));

endmodule

// File: rtl/mim_period_timer.sv
module mim_period_timer #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                restart_i,
  input  logic [PERIOD_W-1:0] limit_i,
  output logic [PERIOD_W-1:0] count_o,
  output logic                expired_o
);

  // Restart dominates; a tick advances the count until it meets the limit
  function automatic logic [PERIOD_W-1:0] step_count(
    input logic [PERIOD_W-1:0] cur,
    input logic [PERIOD_W-1:0] lim,
    input logic                tick,
    input logic                restart);
    if (restart)                 return '0;
    if (tick && (cur < lim))     return cur + 1'b1;
    return cur;
  endfunction

  logic [PERIOD_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= step_count(count_q, limit_i, tick_i, restart_i);
  end

  assign count_o   = count_q;
  assign expired_o = (count_q >= limit_i);

  // R9/R5: a restart always lands the count at zero
  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (count_o == '0));

  // R4: the timer moves only on a tick
  assert_no_tick_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !tick_i) |=> $stable(count_o));

endmodule

// File: rtl/mim_pend_counter.sv
module mim_pend_counter #(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  input  logic               clear_i,
  output logic [COUNT_W-1:0] cnt_o
);

  // A clear keeps only the completion arriving in the same cycle
  function automatic logic [COUNT_W-1:0] step_pend(
    input logic [COUNT_W-1:0] cur,
    input logic               inc,
    input logic               clear);
    logic [COUNT_W-1:0] base;
    base = clear ? '0 : cur;
    return base + {{(COUNT_W-1){1'b0}}, inc};
  endfunction

  logic [COUNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= step_pend(cnt_q, inc_i, clear_i);
  end

  assign cnt_o = cnt_q;

  // R9: after a clear only the coincident completion remains
  assert_clear_keeps_coincident_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_o == {{(COUNT_W-1){1'b0}}, $past(inc_i)}));

  // R2: a counted completion never leaves the count at zero
  assert_inc_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && inc_i) |=> (cnt_o != '0));

endmodule

// File: rtl/mim_moderator.sv
module mim_moderator
  import mim_pkg::*;
#(
  parameter int PERIOD_W   = 8,
  parameter int COUNT_W    = 8,
  parameter int DEF_PERIOD = 16,
  parameter int DEF_THRESH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmpl_i,
  input  logic                usec_tick_i,
  input  logic [1:0]          mode_req_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [COUNT_W-1:0]  thresh_i,
  input  logic                restart_cap_i,
  output logic                irq_o,
  output logic [COUNT_W-1:0]  pend_cnt_o,
  output logic                expired_o
);

  // Named internal events
  tmr_base_e           cfg_base;
  logic [PERIOD_W-1:0] cfg_period;
  logic [COUNT_W-1:0]  cfg_thresh;
  logic [PERIOD_W-1:0] tmr_count;
  logic                tmr_expired;
  logic [COUNT_W-1:0]  pend_cnt;
  logic                pend_nz;
  logic                thresh_hit;
  logic                fire;
  logic                cfg_load;
  logic                tmr_restart;

  function automatic logic count_reached(
    input logic [COUNT_W-1:0] pend,
    input logic [COUNT_W-1:0] thr);
    return (pend != '0) && (pend >= thr);
  endfunction

  assign pend_nz     = (pend_cnt != '0);
  assign thresh_hit  = count_reached(pend_cnt, cfg_thresh);
  assign fire        = pend_nz && (thresh_hit || tmr_expired);
  assign cfg_load    = fire || !pend_nz;
  assign tmr_restart = fire || ((cfg_base == TMR_FROM_CMPL) && cmpl_i);

  mim_cfg_hold #(
    .PERIOD_W  (PERIOD_W),
    .COUNT_W   (COUNT_W),
    .DEF_PERIOD(DEF_PERIOD),
    .DEF_THRESH(DEF_THRESH)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .mode_req_i(mode_req_i),
    .cap_i     (restart_cap_i),
    .period_i  (period_i),
    .thresh_i  (thresh_i),
    .base_q    (cfg_base),
    .period_q  (cfg_period),
    .thresh_q  (cfg_thresh)
  );

  mim_period_timer #(
    .PERIOD_W(PERIOD_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (usec_tick_i),
    .restart_i(tmr_restart),
    .limit_i  (cfg_period),
    .count_o  (tmr_count),
    .expired_o(tmr_expired)
  );

  mim_pend_counter #(
    .COUNT_W(COUNT_W)
  ) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (cmpl_i),
    .clear_i(fire),
    .cnt_o  (pend_cnt)
  );

  assign irq_o      = fire;
  assign pend_cnt_o = pend_cnt;
  assign expired_o  = tmr_expired;

  logic [COUNT_W-1:0] thresh_floor;
  assign thresh_floor = (cfg_thresh == '0) ? COUNT_W'(1) : cfg_thresh;

  // R11: an interrupt needs something to report
  assert_no_irq_when_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_cnt_o != '0));

  // R3: the waiting count never runs past the threshold
  assert_pend_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= thresh_floor);

  // R5: in completion base a non-firing completion reloads the timer
  assert_cmpl_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_base == TMR_FROM_CMPL) && cmpl_i && !fire) |=> (tmr_count == '0));

  // R10: zero period reports any waiting completion at once
  assert_zero_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_period == '0) && (pend_cnt_o != '0)) |-> irq_o);

endmodule

// File: tb/tb_mim_moderator.sv
module tb_mim_moderator;

  localparam int PW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmpl_i = 1'b0;
  logic          usec_tick_i = 1'b0;
  logic [1:0]    mode_req_i = 2'd0;
  logic [PW-1:0] period_i = 8'd3;
  logic [CW-1:0] thresh_i = 8'd4;
  logic          restart_cap_i = 1'b1;
  logic          irq_o;
  logic [CW-1:0] pend_cnt_o;
  logic          expired_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mim_moderator #(.PERIOD_W(PW), .COUNT_W(CW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmpl_i       (cmpl_i),
    .usec_tick_i  (usec_tick_i),
    .mode_req_i   (mode_req_i),
    .period_i     (period_i),
    .thresh_i     (thresh_i),
    .restart_cap_i(restart_cap_i),
    .irq_o        (irq_o),
    .pend_cnt_o   (pend_cnt_o),
    .expired_o    (expired_o)
  );

  // Row bits: {cmpl, tick, exp_irq, exp_pend[2:0]}; expected values are the
  // outputs seen before the row's inputs are clocked in.
  // Config: interrupt base, period 3, threshold 4.
  localparam logic [5:0] VEC [0:19] = '{
    6'b10_0_000, 6'b10_0_001, 6'b10_0_010, 6'b10_0_011,
    6'b00_1_100, 6'b11_0_000, 6'b01_0_001, 6'b01_0_001,
    6'b10_1_001, 6'b01_0_001, 6'b01_0_001, 6'b00_0_001,
    6'b01_0_001, 6'b00_1_001, 6'b01_0_000, 6'b01_0_000,
    6'b01_0_000, 6'b10_0_000, 6'b00_1_001, 6'b00_0_000
  };

  function automatic string row_tag(input int i);
    case (i)
      1, 2, 3:   return "R2";
      4:         return "R3";
      8:         return "R9";
      7, 13:     return "R4";
      17:        return "R11";
      default:   return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs for one clock edge; returns at the following falling edge
  task automatic cyc(input logic c, input logic t);
    cmpl_i = c;
    usec_tick_i = t;
    @(negedge clk);
    cmpl_i = 1'b0;
    usec_tick_i = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 pend", pend_cnt_o, 0);
    chk("R1 expired", expired_o, 0);
    cyc(0, 0); cyc(0, 0);

    // Table walk: R2 R3 R4 R9 R11
    for (int i = 0; i < 20; i++) begin
      chk({row_tag(i), " irq"}, irq_o, VEC[i][3]);
      chk({row_tag(i), " pend"}, pend_cnt_o, VEC[i][2:0]);
      if (i == 17) chk("R11 expired", expired_o, 1);
      cyc(VEC[i][5], VEC[i][4]);
    end

    // R6 / R3: completion base, steady burst, gaps below the period
    mode_req_i = 2'd1; thresh_i = 8'd8; period_i = 8'd3;
    cyc(0, 0); cyc(0, 0);
    for (int k = 0; k < 8; k++) begin
      cyc(1, 0);
      chk("R6 irq in burst", irq_o, (k == 7) ? 1 : 0);
      chk("R3 pend in burst", pend_cnt_o, k + 1);
      cyc(0, 1); cyc(0, 1);
    end

    // R5: expired timer reloaded by a completion, then idle gap fires
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    chk("R5 expired idle", expired_o, 1);
    cyc(1, 0);
    chk("R5 no irq after reload", irq_o, 0);
    chk("R5 pend", pend_cnt_o, 1);
    cyc(0, 1); cyc(0, 1);
    chk("R5 no irq before period", irq_o, 0);
    cyc(0, 1);
    chk("R5 irq after idle period", irq_o, 1);
    cyc(0, 0);
    chk("R9 pend cleared", pend_cnt_o, 0);

    // R7: reserved encoding behaves as interrupt base
    mode_req_i = 2'd2;
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    cyc(1, 0);
    chk("R7 reserved mode fires on expired timer", irq_o, 1);
    cyc(0, 0);

    // R8: capability clear forces interrupt base
    mode_req_i = 2'd1; restart_cap_i = 1'b0;
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    cyc(1, 0);
    chk("R8 no capability fires on expired timer", irq_o, 1);
    cyc(0, 0);

    // R10: zero period
    restart_cap_i = 1'b1; mode_req_i = 2'd0; period_i = 8'd0; thresh_i = 8'd8;
    cyc(0, 0); cyc(0, 0);
    cyc(1, 0);
    chk("R10 irq", irq_o, 1);
    chk("R10 pend", pend_cnt_o, 1);
    cyc(0, 0);
    chk("R10 idle irq", irq_o, 0);

    // R12: threshold change while pending is held off
    period_i = 8'd3;
    cyc(0, 0); cyc(0, 0);
    cyc(1, 0);
    thresh_i = 8'd1;
    cyc(1, 0);
    chk("R12 old threshold kept irq", irq_o, 0);
    chk("R12 pend", pend_cnt_o, 2);
    seen = 1'b0;
    for (int n = 0; n < 6 && !seen; n++) begin
      cyc(0, 1);
      if (irq_o) seen = 1'b1;
    end
    chk("R12 timer flush", seen, 1);
    cyc(0, 0);
    cyc(1, 0);
    chk("R12 new threshold irq", irq_o, 1);
    cyc(0, 0);
    chk("R12 settled", pend_cnt_o, 0);

    summary();
    $finish;
  end

endmodule